// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer execution unit of a simple register-to-register datapath. Each clock cycle it receives a first operand, a second operand that an upstream shifter has already shifted or rotated, the carry bit that shifter produced, a 4-bit operation code and a set-flags bit. It computes a 32-bit result and a write-enable for the destination register without any clock in between. It also holds the four status flags (negative, zero, carry, overflow) in a small register that changes on the next clock edge.

The operations are add, add with carry, subtract, AND, OR, XOR, bit clear, move and move-not. There are also three probe forms: a compare (subtract), a bit test (AND) and an equality test (XOR). A probe never writes a result and always updates the flags. Every other operation writes its result and touches the flags only when the set-flags bit is high. Add-with-carry takes its carry input from the stored C flag, so an add that sets the flags followed by an add-with-carry forms a 64-bit addition over two register pairs.

The flag register has no sequencing states. It is reset, and after that it either loads new flag values or holds them, once per cycle.

Top module: `flag_alu`

## Requirements
- R1: While rst_n is low, flags_o (bit 3 N, bit 2 Z, bit 1 C, bit 0 V) is 4'b0000.
- R2: ADD (op_code 4'h4) gives opnd_a + opnd_b. ADC (4'h5) gives opnd_a + opnd_b + the stored C flag. Both take the result modulo 2^32 and assert wr_en.
- R3: SUB (4'h2) and CMP (4'hA) compute opnd_a - opnd_b. When they update the flags, C is 1 exactly when there is no borrow, and V is 1 on signed overflow. ADD and ADC set C to the carry out of bit 31, and V on signed overflow.
- R4: The logical operations are AND (4'h0) a&b, ORR (4'hC) a|b, EOR (4'h1) a^b and BIC (4'hE) a&~b. For example, 0x02FA62CA BIC 0x0000FFFF = 0x02FA0000.
- R5: MOV (4'hD) gives opnd_b, and MVN (4'hF) gives ~opnd_b. Both ignore opnd_a.
- R6: TST (4'h8, AND), TEQ (4'h9, XOR) and CMP never assert wr_en and always update the flags, whatever set_flags is. TEQ sets Z exactly when the operands are equal.
- R7: Any operation other than a probe, issued with set_flags low, asserts wr_en and leaves flags_o unchanged.
- R8: A flag update makes N equal result bit 31 and Z equal (result == 0). The new flags show on flags_o after the next rising clock edge.
- R9: A logical operation or move that updates the flags loads C from shift_cout and keeps the previous V.
- R10: ADD with set_flags on the low words, followed by ADC on the high words, gives the correct 64-bit sum, including a carry across the word boundary.
- R11: The undefined op_codes 4'h3, 4'h6, 4'h7 and 4'hB drive wr_en low, result 0, and leave flags_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, already shifted |
| shift_cout | input | 1 | Carry produced by the upstream shifter |
| op_code | input | 4 | Operation select |
| set_flags | input | 1 | Request a flag update for operations that are not probes |
| result | output | 32 | Computed value (also driven for probes) |
| wr_en | output | 1 | Destination write enable |
| flags_o | output | 4 | Stored flags {N, Z, C, V} |

## Verification
The bench walks a chained vector table in which the flag state carries from one row to the next. This catches a flag register that updates without set_flags, or that misses a forced update on a probe. It also catches a design that copies the raw adder carry into C on subtract, which inverts the borrow sense. Rows with the C flag set before a logic operation catch a design that leaves the arithmetic carry or overflow in place instead of taking shift_cout and keeping V. A 64-bit chain with a carry across the word boundary, a TEQ of equal operands, signed overflow at both ends, the undefined codes and a reset in the middle of the run close out the corner cases.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0,
        OP_EOR = 4'h1,
        OP_SUB = 4'h2,
        OP_ADD = 4'h4,
        OP_ADC = 4'h5,
        OP_TST = 4'h8,
        OP_TEQ = 4'h9,
        OP_CMP = 4'hA,
        OP_ORR = 4'hC,
        OP_MOV = 4'hD,
        OP_BIC = 4'hE,
        OP_MVN = 4'hF
    } alu_op_e;

    typedef enum logic [2:0] {
        LG_AND,
        LG_ORR,
        LG_EOR,
        LG_BIC,
        LG_MOV,
        LG_MVN
    } logic_sel_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/flag_alu_decode.sv
module flag_alu_decode
    import flag_alu_pkg::*;
(
    input  logic [3:0] op_code,
    output logic       known,
    output logic       probe,
    output logic       arith,
    output logic       sub,
    output logic       use_c,
    output logic_sel_e lsel
);

    always_comb begin
        known = 1'b1;
        probe = 1'b0;
        arith = 1'b0;
        sub   = 1'b0;
        use_c = 1'b0;
        lsel  = LG_AND;
        unique case (op_code)
            OP_AND: lsel = LG_AND;
            OP_EOR: lsel = LG_EOR;
            OP_ORR: lsel = LG_ORR;
            OP_BIC: lsel = LG_BIC;
            OP_MOV: lsel = LG_MOV;
            OP_MVN: lsel = LG_MVN;
            OP_ADD: arith = 1'b1;
            OP_ADC: begin
                arith = 1'b1;
                use_c = 1'b1;
            end
            OP_SUB: begin
                arith = 1'b1;
                sub   = 1'b1;
            end
            OP_CMP: begin
                arith = 1'b1;
                sub   = 1'b1;
                probe = 1'b1;
            end
            OP_TST: begin
                lsel  = LG_AND;
                probe = 1'b1;
            end
            OP_TEQ: begin
                lsel  = LG_EOR;
                probe = 1'b1;
            end
            default: known = 1'b0;
        endcase
    end

endmodule

// File: rtl/flag_alu_addsub.sv
module flag_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert_b,
    input  logic         carry_in,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff = invert_b ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, carry_in};
        sum   = wide[W-1:0];
        cout  = wide[W];
        ovf   = (a[W-1] == b_eff[W-1]) && (wide[W-1] != a[W-1]);
    end

endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_sel_e   lsel,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (lsel)
            LG_AND:  y = a & b;
            LG_ORR:  y = a | b;
            LG_EOR:  y = a ^ b;
            LG_BIC:  y = a & ~b;
            LG_MOV:  y = b;
            LG_MVN:  y = ~b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] res,
    input  logic         arith,
    input  logic         a_cout,
    input  logic         a_ovf,
    input  logic         shift_cout,
    output flags_t       flags_q
);

    flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (upd) begin
            flags_d.n = res[W-1];
            flags_d.z = (res == '0);
            flags_d.c = arith ? a_cout : shift_cout;
            flags_d.v = arith ? a_ovf : flags_q.v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (flags_q == '0)); // R1

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         shift_cout,
    input  logic [3:0]   op_code,
    input  logic         set_flags,
    output logic [W-1:0] result,
    output logic         wr_en,
    output logic [3:0]   flags_o
);

    logic         known, probe, arith, sub, use_c;
    logic_sel_e   lsel;
    logic [W-1:0] sum, lres;
    logic         a_cout, a_ovf, carry_in, upd;
    flags_t       flags_q;

    flag_alu_decode u_dec (
        .op_code (op_code),
        .known   (known),
        .probe   (probe),
        .arith   (arith),
        .sub     (sub),
        .use_c   (use_c),
        .lsel    (lsel)
    );

    assign carry_in = sub | (use_c & flags_q.c);

    flag_alu_addsub #(.W(W)) u_add (
        .a        (opnd_a),
        .b        (opnd_b),
        .invert_b (sub),
        .carry_in (carry_in),
        .sum      (sum),
        .cout     (a_cout),
        .ovf      (a_ovf)
    );

    flag_alu_logic #(.W(W)) u_log (
        .a    (opnd_a),
        .b    (opnd_b),
        .lsel (lsel),
        .y    (lres)
    );

    always_comb begin
        if (!known)     result = '0;
        else if (arith) result = sum;
        else            result = lres;
        wr_en = known & ~probe;
        upd   = known & (probe | set_flags);
    end

    flag_alu_flags #(.W(W)) u_flg (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (upd),
        .res        (result),
        .arith      (arith),
        .a_cout     (a_cout),
        .a_ovf      (a_ovf),
        .shift_cout (shift_cout),
        .flags_q    (flags_q)
    );

    assign flags_o = flags_q;

    logic is_probe_code, is_logic_code, is_known_code;
    assign is_probe_code = (op_code == 4'h8) || (op_code == 4'h9) || (op_code == 4'hA);
    assign is_logic_code = (op_code == 4'h0) || (op_code == 4'h1) || (op_code == 4'hC)
                        || (op_code == 4'hD) || (op_code == 4'hE) || (op_code == 4'hF);
    assign is_known_code = !((op_code == 4'h3) || (op_code == 4'h6)
                          || (op_code == 4'h7) || (op_code == 4'hB));

    AST_PROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        is_probe_code |-> !wr_en); // R6
    AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_flags && !is_probe_code) |=> $stable(flags_o)); // R7
    AST_N_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (is_known_code && (set_flags || is_probe_code)) |=> (flags_o[3] == $past(result[W-1]))); // R8
    AST_Z_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (is_known_code && (set_flags || is_probe_code)) |=> (flags_o[2] == ($past(result) == '0))); // R8
    AST_LOGIC_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_logic_code && set_flags) |=> $stable(flags_o[0])); // R9
    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !is_known_code |-> (!wr_en && result == '0)); // R11

endmodule

// File: tb/flag_alu_tb_top.sv
`timescale 1ns/1ps
module flag_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        shift_cout = 1'b0;
    logic [3:0]  op_code = 4'h4;
    logic        set_flags = 1'b0;
    logic [31:0] result;
    logic        wr_en;
    logic [3:0]  flags_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flag_alu dut_i (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .shift_cout(shift_cout), .op_code(op_code), .set_flags(set_flags),
        .result(result), .wr_en(wr_en), .flags_o(flags_o)
    );

    // {op, set, shift_cout, a, b, expected result, expected wr_en, expected flags NZCV}
    localparam int NV = 20;
    localparam logic [106:0] VEC [NV] = '{
        {4'h4,1'b1,1'b0,32'h7FFFFFFF,32'h00000001,32'h80000000,1'b1,4'b1001}, // 0  R2 R3 R8 ADD overflow
        {4'h4,1'b0,1'b0,32'h00000001,32'h00000002,32'h00000003,1'b1,4'b1001}, // 1  R7
        {4'h2,1'b1,1'b0,32'h00000005,32'h00000007,32'hFFFFFFFE,1'b1,4'b1000}, // 2  R3 borrow
        {4'h2,1'b1,1'b0,32'h00000007,32'h00000005,32'h00000002,1'b1,4'b0010}, // 3  R3 no borrow
        {4'hA,1'b0,1'b0,32'h80000000,32'h00000001,32'h7FFFFFFF,1'b0,4'b0011}, // 4  R6 R3 CMP overflow
        {4'h5,1'b0,1'b0,32'h00000010,32'h00000020,32'h00000031,1'b1,4'b0011}, // 5  R2 ADC with C=1
        {4'hE,1'b1,1'b0,32'h02FA62CA,32'h0000FFFF,32'h02FA0000,1'b1,4'b0001}, // 6  R4 R9 BIC
        {4'h9,1'b0,1'b1,32'h12345678,32'h12345678,32'h00000000,1'b0,4'b0111}, // 7  R6 TEQ equal
        {4'h8,1'b0,1'b0,32'hF0F0F0F0,32'h0F0F0F0F,32'h00000000,1'b0,4'b0101}, // 8  R6 TST
        {4'hC,1'b1,1'b1,32'h80000000,32'h00000001,32'h80000001,1'b1,4'b1011}, // 9  R4 R9 ORR
        {4'h1,1'b0,1'b0,32'hFF00FF00,32'h0FF00FF0,32'hF0F0F0F0,1'b1,4'b1011}, // 10 R4 R7 EOR
        {4'h0,1'b1,1'b0,32'hFFFF0000,32'h0000FFFF,32'h00000000,1'b1,4'b0101}, // 11 R4 R8 AND zero
        {4'hD,1'b1,1'b1,32'hDEADBEEF,32'h00000000,32'h00000000,1'b1,4'b0111}, // 12 R5 MOV
        {4'hF,1'b1,1'b0,32'h00000000,32'h0000000F,32'hFFFFFFF0,1'b1,4'b1001}, // 13 R5 MVN
        {4'h3,1'b1,1'b1,32'h00000001,32'h00000001,32'h00000000,1'b0,4'b1001}, // 14 R11
        {4'hB,1'b1,1'b0,32'hFFFFFFFF,32'h00000001,32'h00000000,1'b0,4'b1001}, // 15 R11
        {4'h4,1'b1,1'b0,32'hFFFFFFFF,32'h00000001,32'h00000000,1'b1,4'b0110}, // 16 R10 low words
        {4'h5,1'b1,1'b0,32'h00000001,32'h00000002,32'h00000004,1'b1,4'b0000}, // 17 R10 high words
        {4'h5,1'b0,1'b0,32'h00000005,32'h00000006,32'h0000000B,1'b1,4'b0000}, // 18 R2 ADC with C=0
        {4'hA,1'b1,1'b0,32'h00000009,32'h00000009,32'h00000000,1'b0,4'b0110}  // 19 R6 CMP equal
    };

    function automatic string vtag(int i);
        case (i)
            0, 5, 18:       return "R2";
            2, 3:           return "R3";
            4, 7, 8, 19:    return "R6";
            6, 9, 10, 11:   return "R4";
            12, 13:         return "R5";
            14, 15:         return "R11";
            16, 17:         return "R10";
            default:        return "R7";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                bad++;
                total++;
                $display("FAIL watchdog actual=%0d expected<=20000", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset flags", {28'd0, flags_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after release", {28'd0, flags_o}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [106:0] e;
            e = VEC[i];
            op_code    = e[106:103];
            set_flags  = e[102];
            shift_cout = e[101];
            opnd_a     = e[100:69];
            opnd_b     = e[68:37];
            #1;
            check($sformatf("%s vec%0d result", vtag(i), i), result, e[36:5]);
            check($sformatf("%s vec%0d wr_en", vtag(i), i), {31'd0, wr_en}, {31'd0, e[4]});
            @(negedge clk);
            check($sformatf("%s R8 vec%0d flags", vtag(i), i), {28'd0, flags_o}, {28'd0, e[3:0]});
        end

        // R7 with a held operation over several cycles: flags 0110 from the last row stay put
        op_code = 4'hE; set_flags = 1'b0; shift_cout = 1'b1;
        opnd_a = 32'h0; opnd_b = 32'h0;
        repeat (3) @(negedge clk);
        check("R7 held flags", {28'd0, flags_o}, 32'h6);
        check("R7 wr_en", {31'd0, wr_en}, 32'd1);

        // R1 reset in the middle of the run
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset", {28'd0, flags_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after mid-run reset", {28'd0, flags_o}, 32'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule